// File: doc/BRIEF.md
# Randomised Background Check Scheduler

This block decides when background integrity checks and consistency checks of stored partitions are to run. A free-running 40-bit linear feedback shift register supplies pseudo-random numbers. There is one countdown timer for each kind of check. When a timer reloads, it takes the current random value, masks it to the low N bits, and adds one. N is a programmable exponent that is kept separately for each kind of check. When a timer runs out, it raises a pending request for its kind of check. The request stays raised until the check engine acknowledges it.

Requests are routed to partitions through enable inputs. Integrity requests go only to those of the four lockable partitions (the hardware configuration partition and three secret partitions) that report themselves locked. Consistency requests go to the same locked partitions and always go to the life-cycle partition. Both exponents can be written until a one-way configuration lock is cleared. After that they are frozen until reset. A write that is accepted restarts the corresponding timer from a fresh random value, using the new exponent.

Top module: `chk_sched`

## Requirements
- R1: After a synchronous reset, the integrity exponent reads 25, the consistency exponent reads 34, `cfg_open_o` is 1 and all request outputs are 0.
- R2: The random source is a 40-bit shift register seeded with 40'h5AC3E19B27. Each clock it shifts left by one and inserts, at bit 0, the XOR of bits 39, 37, 20 and 18. It never reaches zero.
- R3: While `cfg_open_o` is 1, a write strobe stores `cfg_wdata_i` into the selected exponent, and the new value is visible on its output one cycle later.
- R4: A pulse on `cfg_lock_clr_i` clears `cfg_open_o` permanently until reset. From then on, exponent writes change neither the exponent outputs nor the timers.
- R5: An accepted exponent write reloads that timer with (random value AND (2^N−1)) + 1, using the newly written N. A timer does not expire in the cycle it is written.
- R6: Each timer counts down by one per clock. It expires in the cycle its count is 1, and in that same cycle it reloads with (random value AND (2^N−1)) + 1, using the stored N.
- R7: An expiry sets the pending flag of that kind of check. The flag clears only in a cycle that has an acknowledge and no expiry. Expiries while the flag is set are merged into the one request.
- R8: `integ_req_o` equals, one cycle after the pending flag is updated, the new flag ANDed bitwise with `part_locked_i` (bit 0 is the hardware configuration partition, bits 1 to 3 are the secret partitions).
- R9: `consist_req_o[3:0]` follows the same rule as R8, using the consistency flag. Bit 4 (the life-cycle partition) equals the consistency flag with no enable applied.
- R10: An exponent of 0 gives a period of one cycle, so that kind of check expires on every clock.
- R11: A written exponent value above 40 is stored and read back as 40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cfg_wdata_i | input | 6 | Exponent write data |
| integ_exp_we_i | input | 1 | Write strobe for the integrity exponent |
| consist_exp_we_i | input | 1 | Write strobe for the consistency exponent |
| cfg_lock_clr_i | input | 1 | Write-1-to-clear pulse for the configuration lock |
| part_locked_i | input | 4 | Locked status of the hardware configuration partition and the three secret partitions |
| integ_ack_i | input | 1 | Acknowledge of the integrity request |
| consist_ack_i | input | 1 | Acknowledge of the consistency request |
| integ_req_o | output | 4 | Integrity check request, one bit per lockable partition |
| consist_req_o | output | 5 | Consistency check request; bit 4 is the life-cycle partition |
| integ_exp_o | output | 6 | Stored integrity exponent |
| consist_exp_o | output | 6 | Stored consistency exponent |
| cfg_open_o | output | 1 | 1 while the exponents are writable |

## Verification
The scheduler runs with small exponents (2 and 3) under three acknowledge patterns, and the outputs are compared every cycle with a bench model that steps its own copy of the random register:
- Sparse periodic acknowledges show whether random periods are drawn and reloaded at the right cycle.
- A permanent acknowledge separates expiry pulses from held requests.
- An acknowledge withheld for a long stretch shows that expiries merge into one held request instead of queueing.

Partition-enable patterns of all-clear, alternating and all-set show the difference between locked-only routing and the life-cycle bit, which is always routed. Exponents of 0, 41 and 63 probe the one-cycle period and the clamp. Writes after the lock is cleared show that both the readback and the timer phase are left untouched.

// File: rtl/chk_sched_pkg.sv
package chk_sched_pkg;
  // Kinds of background check; value doubles as the timer index.
  typedef enum logic [0:0] {
    KIND_INTEG   = 1'b0,
    KIND_CONSIST = 1'b1
  } chk_kind_e;

  localparam int unsigned NUM_KINDS = 2;
endpackage

// File: rtl/chk_sched_lfsr.sv
module chk_sched_lfsr #(
  parameter int unsigned       WIDTH = 40,
  parameter logic [WIDTH-1:0]  SEED  = 40'h5AC3E19B27,
  parameter logic [WIDTH-1:0]  TAPS  = 40'hA000140000
) (
  input  logic             clk_i,
  input  logic             rst_i,
  output logic [WIDTH-1:0] state_o
);
  logic [WIDTH-1:0] state_q;
  logic             feedback;

  assign feedback = ^(state_q & TAPS);

  always_ff @(posedge clk_i) begin
    if (rst_i) state_q <= SEED;
    else       state_q <= {state_q[WIDTH-2:0], feedback};
  end

  assign state_o = state_q;
endmodule

// File: rtl/chk_sched_cfg.sv
module chk_sched_cfg #(
  parameter int unsigned EXP_W     = 6,
  parameter int unsigned MAX_EXP   = 40,
  parameter int unsigned NUM_KINDS = 2,
  parameter int unsigned RST_EXP0  = 25,
  parameter int unsigned RST_EXP1  = 34
) (
  input  logic                            clk_i,
  input  logic                            rst_i,
  input  logic [EXP_W-1:0]                wdata_i,
  input  logic [NUM_KINDS-1:0]            we_i,
  input  logic                            lock_clr_i,
  output logic [NUM_KINDS-1:0][EXP_W-1:0] exp_o,
  output logic [NUM_KINDS-1:0]            load_o,
  output logic [EXP_W-1:0]                load_exp_o,
  output logic                            open_o
);
  localparam logic [EXP_W-1:0] MaxExpC = EXP_W'(MAX_EXP);

  logic             open_q;
  logic [EXP_W-1:0] clamped;

  // Exponent is clamped before storage so the mask never exceeds the source width.
  assign clamped    = (wdata_i > MaxExpC) ? MaxExpC : wdata_i;
  assign load_exp_o = clamped;
  assign open_o     = open_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) open_q <= 1'b1;
    else if (lock_clr_i) open_q <= 1'b0;
  end

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_exp
    localparam logic [EXP_W-1:0] RstVal = EXP_W'((k == 0) ? RST_EXP0 : RST_EXP1);
    logic [EXP_W-1:0] exp_q;

    assign load_o[k] = we_i[k] & open_q;
    assign exp_o[k]  = exp_q;

    always_ff @(posedge clk_i) begin
      if (rst_i)          exp_q <= RstVal;
      else if (load_o[k]) exp_q <= clamped;
    end
  end
endmodule

// File: rtl/chk_sched_timer.sv
module chk_sched_timer #(
  parameter int unsigned          LFSR_W  = 40,
  parameter int unsigned          EXP_W   = 6,
  parameter int unsigned          RST_EXP = 25,
  parameter logic [LFSR_W-1:0]    SEED    = 40'h5AC3E19B27
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [LFSR_W-1:0] rand_i,
  input  logic [EXP_W-1:0]  exp_i,
  input  logic              ld_i,
  input  logic [EXP_W-1:0]  ld_exp_i,
  input  logic              ack_i,
  output logic              pend_d_o
);
  localparam int unsigned CNT_W = LFSR_W + 1;

  function automatic logic [LFSR_W-1:0] mask_of(input logic [EXP_W-1:0] n);
    logic [CNT_W-1:0] sh;
    sh = CNT_W'(1) << n;
    return LFSR_W'(sh - CNT_W'(1));
  endfunction

  function automatic logic [CNT_W-1:0] period_of(input logic [LFSR_W-1:0] r,
                                                 input logic [EXP_W-1:0]  n);
    return {1'b0, r & mask_of(n)} + CNT_W'(1);
  endfunction

  localparam logic [CNT_W-1:0] RstCnt = period_of(SEED, EXP_W'(RST_EXP));

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pend_q, pend_d;
  logic             expire;

  assign expire = !ld_i && (cnt_q == CNT_W'(1));

  always_comb begin
    if (ld_i)        cnt_d = period_of(rand_i, ld_exp_i);
    else if (expire) cnt_d = period_of(rand_i, exp_i);
    else             cnt_d = cnt_q - CNT_W'(1);
  end

  // Expiries merge into one outstanding request; a new expiry beats an acknowledge.
  assign pend_d   = expire | (pend_q & ~ack_i);
  assign pend_d_o = pend_d;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q  <= RstCnt;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end
endmodule

// File: rtl/chk_sched.sv
module chk_sched
  import chk_sched_pkg::*;
#(
  parameter int unsigned       LFSR_W          = 40,
  parameter int unsigned       EXP_W           = 6,
  parameter int unsigned       NUM_LOCKABLE    = 4,
  parameter int unsigned       INTEG_RST_EXP   = 25,
  parameter int unsigned       CONSIST_RST_EXP = 34,
  parameter logic [LFSR_W-1:0] SEED            = 40'h5AC3E19B27,
  parameter logic [LFSR_W-1:0] TAPS            = 40'hA000140000
) (
  input  logic                    clk_i,
  input  logic                    rst_i,
  input  logic [EXP_W-1:0]        cfg_wdata_i,
  input  logic                    integ_exp_we_i,
  input  logic                    consist_exp_we_i,
  input  logic                    cfg_lock_clr_i,
  input  logic [NUM_LOCKABLE-1:0] part_locked_i,
  input  logic                    integ_ack_i,
  input  logic                    consist_ack_i,
  output logic [NUM_LOCKABLE-1:0] integ_req_o,
  output logic [NUM_LOCKABLE:0]   consist_req_o,
  output logic [EXP_W-1:0]        integ_exp_o,
  output logic [EXP_W-1:0]        consist_exp_o,
  output logic                    cfg_open_o
);
  localparam int unsigned II = int'(KIND_INTEG);
  localparam int unsigned IC = int'(KIND_CONSIST);

  logic [LFSR_W-1:0]                rand_val;
  logic [NUM_KINDS-1:0][EXP_W-1:0]  exp_val;
  logic [NUM_KINDS-1:0]             we, load, ack, pend_d;
  logic [EXP_W-1:0]                 load_exp;
  logic [NUM_LOCKABLE-1:0]          integ_req_q;
  logic [NUM_LOCKABLE:0]            consist_req_q;

  assign we[II]  = integ_exp_we_i;
  assign we[IC]  = consist_exp_we_i;
  assign ack[II] = integ_ack_i;
  assign ack[IC] = consist_ack_i;

  chk_sched_lfsr #(.WIDTH(LFSR_W), .SEED(SEED), .TAPS(TAPS)) u_lfsr (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .state_o (rand_val)
  );

  chk_sched_cfg #(
    .EXP_W    (EXP_W),
    .MAX_EXP  (LFSR_W),
    .NUM_KINDS(NUM_KINDS),
    .RST_EXP0 (INTEG_RST_EXP),
    .RST_EXP1 (CONSIST_RST_EXP)
  ) u_cfg (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .wdata_i   (cfg_wdata_i),
    .we_i      (we),
    .lock_clr_i(cfg_lock_clr_i),
    .exp_o     (exp_val),
    .load_o    (load),
    .load_exp_o(load_exp),
    .open_o    (cfg_open_o)
  );

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_timer
    chk_sched_timer #(
      .LFSR_W (LFSR_W),
      .EXP_W  (EXP_W),
      .RST_EXP((k == 0) ? INTEG_RST_EXP : CONSIST_RST_EXP),
      .SEED   (SEED)
    ) u_timer (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .rand_i  (rand_val),
      .exp_i   (exp_val[k]),
      .ld_i    (load[k]),
      .ld_exp_i(load_exp),
      .ack_i   (ack[k]),
      .pend_d_o(pend_d[k])
    );
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      integ_req_q   <= '0;
      consist_req_q <= '0;
    end else begin
      integ_req_q   <= part_locked_i & {NUM_LOCKABLE{pend_d[II]}};
      consist_req_q <= {1'b1, part_locked_i} & {(NUM_LOCKABLE+1){pend_d[IC]}};
    end
  end

  assign integ_req_o   = integ_req_q;
  assign consist_req_o = consist_req_q;
  assign integ_exp_o   = exp_val[II];
  assign consist_exp_o = exp_val[IC];
endmodule

// File: rtl/chk_sched_chk.sv
module chk_sched_chk #(
  parameter int unsigned EXP_W        = 6,
  parameter int unsigned NUM_LOCKABLE = 4,
  parameter int unsigned MAX_EXP      = 40
) (
  input logic                    clk_i,
  input logic                    rst_i,
  input logic [NUM_LOCKABLE-1:0] part_locked_i,
  input logic                    consist_ack_i,
  input logic [NUM_LOCKABLE-1:0] integ_req_o,
  input logic [NUM_LOCKABLE:0]   consist_req_o,
  input logic [EXP_W-1:0]        integ_exp_o,
  input logic [EXP_W-1:0]        consist_exp_o,
  input logic                    cfg_open_o
);
  // R4
  lock_sticky_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !cfg_open_o |=> !cfg_open_o);

  // R4
  frozen_exp_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    !cfg_open_o |=> ($stable(integ_exp_o) && $stable(consist_exp_o)));

  // R11
  exp_clamp_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (integ_exp_o <= EXP_W'(MAX_EXP)) && (consist_exp_o <= EXP_W'(MAX_EXP)));

  // R7
  held_req_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (consist_req_o[NUM_LOCKABLE] && !consist_ack_i) |=> consist_req_o[NUM_LOCKABLE]);

  // R8
  integ_route_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (|integ_req_o) |-> ((integ_req_o & ~$past(part_locked_i)) == '0));

  // R9
  consist_route_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (|consist_req_o[NUM_LOCKABLE-1:0]) |-> consist_req_o[NUM_LOCKABLE]);
endmodule

bind chk_sched chk_sched_chk #(
  .EXP_W       (EXP_W),
  .NUM_LOCKABLE(NUM_LOCKABLE),
  .MAX_EXP     (LFSR_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_i        (rst_i),
  .part_locked_i(part_locked_i),
  .consist_ack_i(consist_ack_i),
  .integ_req_o  (integ_req_o),
  .consist_req_o(consist_req_o),
  .integ_exp_o  (integ_exp_o),
  .consist_exp_o(consist_exp_o),
  .cfg_open_o   (cfg_open_o)
);

// File: tb/chk_sched_bench.sv
module chk_sched_bench;
  localparam int NL = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] wdata = '0;
  logic       we_i = 1'b0, we_c = 1'b0, lock_clr = 1'b0;
  logic [NL-1:0] locked = '0;
  logic       ack_i = 1'b0, ack_c = 1'b0;
  logic [NL-1:0] integ_req;
  logic [NL:0]   consist_req;
  logic [5:0] integ_exp, consist_exp;
  logic       cfg_open;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  chk_sched u_chk_sched (
    .clk_i(clk), .rst_i(rst), .cfg_wdata_i(wdata),
    .integ_exp_we_i(we_i), .consist_exp_we_i(we_c), .cfg_lock_clr_i(lock_clr),
    .part_locked_i(locked), .integ_ack_i(ack_i), .consist_ack_i(ack_c),
    .integ_req_o(integ_req), .consist_req_o(consist_req),
    .integ_exp_o(integ_exp), .consist_exp_o(consist_exp), .cfg_open_o(cfg_open)
  );

  // ---------------- reference model ----------------
  localparam logic [39:0] SEED = 40'h5AC3E19B27;
  logic [39:0] m_rand;
  int          m_ie, m_ce;
  bit          m_open;
  logic [40:0] m_ci, m_cc;
  bit          m_pi, m_pc;
  logic [NL-1:0] m_req_i;
  logic [NL:0]   m_req_c;

  function automatic logic [39:0] mk_mask(input int n);
    logic [39:0] m = '0;
    for (int b = 0; b < 40; b++) if (b < n) m[b] = 1'b1;
    return m;
  endfunction

  function automatic logic [40:0] draw(input logic [39:0] r, input int n);
    return {1'b0, r & mk_mask(n)} + 41'd1;
  endfunction

  function automatic logic [39:0] step_rand(input logic [39:0] s);
    int taps[4] = '{39, 37, 20, 18};
    logic fb = 1'b0;
    foreach (taps[t]) fb = fb ^ s[taps[t]];
    return {s[38:0], fb};
  endfunction

  function automatic int clampv(input int v);
    return (v > 40) ? 40 : v;
  endfunction

  always @(posedge clk) begin
    bit exp_i, exp_c, npi, npc;
    if (rst) begin
      m_rand <= SEED; m_ie <= 25; m_ce <= 34; m_open <= 1;
      m_ci <= draw(SEED, 25); m_cc <= draw(SEED, 34);
      m_pi <= 0; m_pc <= 0; m_req_i <= '0; m_req_c <= '0;
    end else begin
      exp_i = 0; exp_c = 0;
      if (we_i && m_open) begin
        m_ie <= clampv(int'(wdata)); m_ci <= draw(m_rand, clampv(int'(wdata)));
      end else if (m_ci == 41'd1) begin
        exp_i = 1; m_ci <= draw(m_rand, m_ie);
      end else m_ci <= m_ci - 41'd1;
      if (we_c && m_open) begin
        m_ce <= clampv(int'(wdata)); m_cc <= draw(m_rand, clampv(int'(wdata)));
      end else if (m_cc == 41'd1) begin
        exp_c = 1; m_cc <= draw(m_rand, m_ce);
      end else m_cc <= m_cc - 41'd1;
      npi = exp_i || (m_pi && !ack_i);
      npc = exp_c || (m_pc && !ack_c);
      m_pi <= npi; m_pc <= npc;
      m_req_i <= npi ? locked : '0;
      m_req_c <= npc ? {1'b1, locked} : '0;
      if (lock_clr) m_open <= 0;
      m_rand <= step_rand(m_rand);
    end
  end

  // ---------------- checking ----------------
  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      check(integ_req == m_req_i, "R2 R6 R8", "integ_req", integ_req, m_req_i);
      check(consist_req == m_req_c, "R5 R7 R9", "consist_req", consist_req, m_req_c);
      check(int'(integ_exp) == m_ie && int'(consist_exp) == m_ce, "R3", "exponents",
            {integ_exp, consist_exp}, {m_ie[5:0], m_ce[5:0]});
      check(cfg_open == m_open, "R4", "cfg_open", cfg_open, m_open);
    end
  end

  task automatic write_exp(input bit integ, input int v);
    @(negedge clk);
    wdata <= 6'(v); we_i <= integ; we_c <= !integ;
    @(negedge clk);
    we_i <= 0; we_c <= 0;
  endtask

  task automatic run(input int n, input int pi, input int pc);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      ack_i <= (pi == 1) || (pi > 1 && (i % pi) == 0);
      ack_c <= (pc == 1) || (pc > 1 && (i % pc) == 0);
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    check(integ_exp == 6'd25, "R1", "integ_exp", integ_exp, 25);
    check(consist_exp == 6'd34, "R1", "consist_exp", consist_exp, 34);
    check(cfg_open == 1'b1, "R1", "cfg_open", cfg_open, 1);
    check(integ_req == '0 && consist_req == '0, "R1", "requests",
          {integ_req, consist_req}, 0);
    rst <= 0;

    write_exp(1, 3);
    check(integ_exp == 6'd3, "R3", "integ_exp readback", integ_exp, 3);
    write_exp(0, 2);
    check(consist_exp == 6'd2, "R3", "consist_exp readback", consist_exp, 2);

    locked <= 4'b0000; run(300, 5, 4);
    locked <= 4'b1010; run(300, 1, 3);
    locked <= 4'b1111; run(300, 6, 1);

    // R7 withheld acknowledge keeps one merged request
    run(60, 0, 0);
    check(consist_req[NL] == 1'b1, "R7", "held consistency req", consist_req[NL], 1);
    check(integ_req == 4'b1111, "R7", "held integrity req", integ_req, 4'b1111);
    run(50, 2, 3);

    // R10 exponent zero: expiry every clock
    write_exp(1, 0);
    run(3, 1, 1);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(integ_req == 4'b1111, "R10", "period one", integ_req, 4'b1111);
    end

    // R11 clamp
    write_exp(0, 63);
    check(consist_exp == 6'd40, "R11", "clamp 63", consist_exp, 40);
    write_exp(1, 41);
    check(integ_exp == 6'd40, "R11", "clamp 41", integ_exp, 40);
    write_exp(1, 2);
    write_exp(0, 3);
    locked <= 4'b0101; run(200, 3, 2);

    // R4 lock clear, later writes ignored
    @(negedge clk); lock_clr <= 1;
    @(negedge clk); lock_clr <= 0;
    check(cfg_open == 1'b0, "R4", "cfg_open cleared", cfg_open, 0);
    write_exp(1, 9);
    check(integ_exp == 6'd2, "R4", "integ_exp frozen", integ_exp, 2);
    write_exp(0, 0);
    check(consist_exp == 6'd3, "R4", "consist_exp frozen", consist_exp, 3);
    run(200, 4, 5);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule